// File: doc/BRIEF.md
# Dual-Clock BCD Up/Down Digit Counter

This block holds one decimal digit in 8421 BCD code and moves it up or down in response to two separate count clocks. One clock steps the digit up and the other steps it down. An active-high clear forces the digit to zero, and an active-low load copies a 4-bit data word into it. Both take effect at once, without waiting for a clock edge, and both override counting. Clear wins over load.

The two count clocks are treated as slow signals. Each passes through a two-stage synchronizer onto a single fast system clock, and a registered edge detector turns the synchronized level into a one-cycle step request. A count step therefore lands three system clocks after the count clock rises. Two active-low outputs let digits be chained without glue logic. The carry output goes low while the digit sits at nine and the up clock is low. The borrow output goes low while the digit sits at zero and the down clock is low. Each output returns high on the same system clock edge at which the digit wraps, so it can drive the matching count clock of the next, more significant digit directly.

Top module: `bcd_updown_digit`

## Requirements
- R1: Starting from a value in 0..9, the stored digit stays in 0..9 and counting up from 9 gives 0.
- R2: A rising edge on `cnt_up` while `cnt_dn` is high adds one to the digit, three system clocks after the edge is sampled.
- R3: A rising edge on `cnt_dn` while `cnt_up` is high subtracts one from the digit, and counting down from 0 gives 9.
- R4: With both count clocks high the digit holds its value, and rising edges on both count clocks in the same system cycle leave the digit unchanged.
- R5: While `clr` is high, `q` reads 0 in the same cycle, with no clock edge needed, even while `load_n` is low. The stored digit is 0 after `clr` is released.
- R6: While `load_n` is low and `clr` is low, `q` follows `din` in the same cycle and count clock edges have no effect. After release the digit keeps the last loaded value.
- R7: `carry_n` is low only while `q` is 9 and the synchronized `cnt_up` is low. It goes high on the edge where the digit wraps from 9 to 0.
- R8: `borrow_n` is low only while `q` is 0 and the synchronized `cnt_dn` is low. It goes high on the edge where the digit wraps from 0 to 9.
- R9: A loaded value from 10 to 15 counts up along the binary sequence, with 15 going to 0, and counts down to the value minus one.
- R10: The synchronous system reset `rst` clears the digit to 0. After reset, with both count clocks high, `carry_n` and `borrow_n` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the count clocks |
| rst | input | 1 | Synchronous active-high system reset |
| cnt_up | input | 1 | Count-up clock, active on the rising edge, idle high |
| cnt_dn | input | 1 | Count-down clock, active on the rising edge, idle high |
| clr | input | 1 | Immediate active-high clear, highest priority |
| load_n | input | 1 | Immediate active-low load of `din` |
| din | input | 4 | Value to load |
| q | output | 4 | Current BCD digit |
| carry_n | output | 1 | Active-low terminal count up, drives the next digit's `cnt_up` |
| borrow_n | output | 1 | Active-low terminal count down, drives the next digit's `cnt_dn` |

## Verification
The hardest situations to reach are the wraps of a cascaded pair: a carry or borrow must travel through the upper digit's own synchronizer and edge detector before that digit moves. The bench chains two digits to form a 00..99 counter. It loads 39, 98 and 01 directly, so the carry and borrow boundaries are only a few clock pulses away. It holds the count clock low long enough to observe `carry_n` or `borrow_n` asserted, then releases it and checks both digits after the ripple. Simultaneous up and down edges, and count pulses that arrive while a load is held, are driven from the same negative edge so that they meet in a single sampling cycle.

// File: rtl/bcd_updown_pkg.sv
package bcd_updown_pkg;

  localparam int DIGIT_W = 4;
  localparam logic [DIGIT_W-1:0] DIGIT_TOP = 4'd9;

  typedef logic [DIGIT_W-1:0] digit_t;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_INC  = 2'd1,
    STEP_DEC  = 2'd2
  } step_e;

  // Up step: 9 wraps to 0; 10..15 follow binary order, 15 rolls to 0.
  function automatic digit_t digit_inc(input digit_t v);
    if (v == DIGIT_TOP) return '0;
    return v + 1'b1;
  endfunction

  // Down step: 0 wraps to 9; everything else moves down by one.
  function automatic digit_t digit_dec(input digit_t v);
    if (v == '0) return DIGIT_TOP;
    return v - 1'b1;
  endfunction

endpackage

// File: rtl/bcd_sync.sv
module bcd_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= RST_VAL;
        else     chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/bcd_edge.sv
module bcd_edge #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise,
  output logic lvl_d
);

  always_ff @(posedge clk) begin
    if (rst) lvl_d <= RST_VAL;
    else     lvl_d <= lvl;
  end

  assign rise = lvl & ~lvl_d;

endmodule

// File: rtl/bcd_step_sel.sv
module bcd_step_sel
  import bcd_updown_pkg::*;
(
  input  logic  up_rise,
  input  logic  dn_rise,
  input  logic  up_lvl,
  input  logic  dn_lvl,
  output step_e step
);

  always_comb begin
    step = STEP_HOLD;
    if (up_rise && !dn_rise && dn_lvl)      step = STEP_INC;
    else if (dn_rise && !up_rise && up_lvl) step = STEP_DEC;
  end

endmodule

// File: rtl/bcd_updown_digit.sv
module bcd_updown_digit
  import bcd_updown_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cnt_up,
  input  logic               cnt_dn,
  input  logic               clr,
  input  logic               load_n,
  input  logic [DIGIT_W-1:0] din,
  output logic [DIGIT_W-1:0] q,
  output logic               carry_n,
  output logic               borrow_n
);

  logic   up_s, dn_s;
  logic   up_rise, dn_rise;
  logic   up_d, dn_d;
  step_e  step;
  digit_t cnt_q;

  bcd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_up (
    .clk(clk), .rst(rst), .d(cnt_up), .q(up_s)
  );
  bcd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_dn (
    .clk(clk), .rst(rst), .d(cnt_dn), .q(dn_s)
  );

  bcd_edge #(.RST_VAL(1'b1)) u_edge_up (
    .clk(clk), .rst(rst), .lvl(up_s), .rise(up_rise), .lvl_d(up_d)
  );
  bcd_edge #(.RST_VAL(1'b1)) u_edge_dn (
    .clk(clk), .rst(rst), .lvl(dn_s), .rise(dn_rise), .lvl_d(dn_d)
  );

  bcd_step_sel u_step (
    .up_rise(up_rise), .dn_rise(dn_rise),
    .up_lvl(up_s), .dn_lvl(dn_s),
    .step(step)
  );

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (clr)     cnt_q <= '0;
    else if (!load_n) cnt_q <= din;
    else begin
      case (step)
        STEP_INC: cnt_q <= digit_inc(cnt_q);
        STEP_DEC: cnt_q <= digit_dec(cnt_q);
        default:  cnt_q <= cnt_q;
      endcase
    end
  end

  // Clear and load reach the output without waiting for a clock edge.
  always_comb begin
    if (clr)          q = '0;
    else if (!load_n) q = din;
    else              q = cnt_q;
  end

  // The delayed level switches on the same edge that applies the step.
  assign carry_n  = ~((q == DIGIT_TOP) && !up_d);
  assign borrow_n = ~((q == '0)        && !dn_d);

endmodule

// File: rtl/bcd_updown_digit_chk.sv
module bcd_updown_digit_chk
  import bcd_updown_pkg::*;
(
  input logic   clk,
  input logic   rst,
  input logic   clr,
  input logic   load_n,
  input digit_t q,
  input logic   carry_n,
  input logic   borrow_n,
  input digit_t cnt_q,
  input step_e  step
);

  // R10
  rst_clear_chk: assert property (@(posedge clk) rst |=> (cnt_q == '0));

  // R5
  clr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_q == '0));

  // R1
  range_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && load_n && cnt_q <= DIGIT_TOP) |=> (cnt_q <= DIGIT_TOP));

  // R7
  carry_at_top_chk: assert property (@(posedge clk) disable iff (rst)
    !carry_n |-> (q == DIGIT_TOP));

  // R8
  borrow_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !borrow_n |-> (q == '0));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && load_n && step == STEP_HOLD) |=> $stable(cnt_q));

endmodule

bind bcd_updown_digit bcd_updown_digit_chk u_chk (
  .clk(clk), .rst(rst), .clr(clr), .load_n(load_n), .q(q),
  .carry_n(carry_n), .borrow_n(borrow_n), .cnt_q(cnt_q), .step(step)
);

// File: tb/tb_bcd_updown_digit.sv
`timescale 1ns/1ps
module tb_bcd_updown_digit;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       up = 1'b1, dn = 1'b1, clr = 1'b0;
  logic       ld_lo_n = 1'b1, ld_hi_n = 1'b1;
  logic [3:0] din_lo = '0, din_hi = '0;
  logic [3:0] q_lo, q_hi;
  logic       carry_lo, borrow_lo, carry_hi, borrow_hi;
  int         n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  bcd_updown_digit dut (
    .clk(clk), .rst(rst), .cnt_up(up), .cnt_dn(dn), .clr(clr),
    .load_n(ld_lo_n), .din(din_lo), .q(q_lo),
    .carry_n(carry_lo), .borrow_n(borrow_lo)
  );

  bcd_updown_digit dut_hi (
    .clk(clk), .rst(rst), .cnt_up(carry_lo), .cnt_dn(borrow_lo), .clr(clr),
    .load_n(ld_hi_n), .din(din_hi), .q(q_hi),
    .carry_n(carry_hi), .borrow_n(borrow_hi)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pair_val();
    return int'(q_hi) * 10 + int'(q_lo);
  endfunction

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_pair(input int v);
    @(negedge clk);
    din_hi = 4'(v / 10); din_lo = 4'(v % 10);
    ld_hi_n = 1'b0; ld_lo_n = 1'b0;
    wait_n(2);
    ld_hi_n = 1'b1; ld_lo_n = 1'b1;
    wait_n(2);
  endtask

  task automatic pulse_up(input int n);
    for (int i = 0; i < n; i++) begin
      up = 1'b0; wait_n(6);
      up = 1'b1; wait_n(8);
    end
  endtask

  task automatic pulse_dn(input int n);
    for (int i = 0; i < n; i++) begin
      dn = 1'b0; wait_n(6);
      dn = 1'b1; wait_n(8);
    end
  endtask

  task automatic t_reset();
    wait_n(6); rst = 1'b0; wait_n(2);
    chk("R10 q after reset", pair_val(), 0);
    chk("R10 carry_n after reset", carry_lo, 1);
    chk("R10 borrow_n after reset", borrow_lo, 1);
  endtask

  task automatic t_count_up();
    pulse_up(12);
    chk("R2 twelve up steps", pair_val(), 12);
    load_pair(39);
    up = 1'b0; wait_n(6);
    chk("R7 carry_n low at 9 with up low", carry_lo, 0);
    up = 1'b1; wait_n(10);
    chk("R7 carry_n released after wrap", carry_lo, 1);
    chk("R1 low digit 9 wraps into 40", pair_val(), 40);
  endtask

  task automatic t_wrap_up();
    load_pair(98);
    pulse_up(2);
    chk("R1 98 plus two wraps to 00", pair_val(), 0);
  endtask

  task automatic t_wrap_down();
    load_pair(1);
    pulse_dn(1);
    chk("R3 01 minus one", pair_val(), 0);
    dn = 1'b0; wait_n(6);
    chk("R8 borrow_n low at 0 with dn low", borrow_lo, 0);
    dn = 1'b1; wait_n(10);
    chk("R8 borrow_n released after wrap", borrow_lo, 1);
    chk("R3 00 minus one wraps to 99", pair_val(), 99);
  endtask

  task automatic t_hold();
    load_pair(57);
    wait_n(20);
    chk("R4 both clocks high hold", pair_val(), 57);
    @(negedge clk); up = 1'b0; dn = 1'b0; wait_n(6);
    up = 1'b1; dn = 1'b1; wait_n(10);
    chk("R4 simultaneous rising edges hold", pair_val(), 57);
  endtask

  task automatic t_load_during_count();
    load_pair(20);
    up = 1'b0; wait_n(6);
    din_lo = 4'd5; ld_lo_n = 1'b0; #1;
    chk("R6 q follows din before any edge", q_lo, 5);
    @(negedge clk); up = 1'b1; wait_n(8);
    chk("R6 up edge ignored while loading", q_lo, 5);
    ld_lo_n = 1'b1; wait_n(6);
    chk("R6 loaded value kept after release", pair_val(), 25);
    pulse_up(1);
    chk("R2 counting resumes after load", pair_val(), 26);
  endtask

  task automatic t_clr_priority();
    load_pair(44);
    @(negedge clk);
    din_lo = 4'd7; ld_lo_n = 1'b0; clr = 1'b1; #1;
    chk("R5 clr beats load immediately", q_lo, 0);
    chk("R5 clr clears upper digit immediately", q_hi, 0);
    wait_n(2); clr = 1'b0; ld_lo_n = 1'b1; wait_n(2);
    chk("R5 digit zero after clr release", pair_val(), 0);
  endtask

  task automatic t_invalid_codes();
    @(negedge clk); din_lo = 4'd12; ld_lo_n = 1'b0; wait_n(2); ld_lo_n = 1'b1; wait_n(2);
    pulse_up(1); chk("R9 12 up to 13", q_lo, 13);
    pulse_up(2); chk("R9 13 up twice to 15", q_lo, 15);
    pulse_up(1); chk("R9 15 up to 0", q_lo, 0);
    chk("R9 no carry from 15", q_hi, 0);
    @(negedge clk); din_lo = 4'd10; ld_lo_n = 1'b0; wait_n(2); ld_lo_n = 1'b1; wait_n(2);
    pulse_dn(1); chk("R9 10 down to 9", q_lo, 9);
    chk("R9 no borrow from 10", q_hi, 0);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_count_up();
    t_wrap_up();
    t_wrap_down();
    t_hold();
    t_load_during_count();
    t_clr_priority();
    t_invalid_codes();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule